// File: doc/BRIEF.md
# Configurable Read Output Pipeline

This block forms the read-data and output-enable path of a synchronous burst memory. Each cycle the memory's input registers hand it one captured command (read, write, deselect, or hold) together with the data the array returns for the captured address. The block turns these into a data word and a per-lane drive enable that together model a tri-state data bus. Lane count and lane width are parameters.

Two run-time mode inputs shape the timing. The first sets where read data comes from. In flow-through mode it comes straight from the array in the cycle the read is captured. In pipelined mode it comes from a rising-edge output register one cycle later. The second sets how quickly a deselect removes the drivers. In dual-cycle mode a deselect has the same pipeline depth as a read. In single-cycle mode it is one stage shallower, so it acts in the very cycle it is captured.

An asynchronous active-low output enable can only gate drivers off. A write cycle always leaves the bus undriven. If a pipelined read would still have driven the bus in the cycle write data is sampled, the block raises a contention flag.

Top module: `read_out_pipe`

## Requirements
- R1: With `mode_flow_n` low (flow-through), whenever the bus is driven `dq_out` equals `rd_data` of the same cycle. A read command (`cap_cmd` = 2'b01) drives the bus in the cycle it is captured.
- R2: With `mode_flow_n` high (pipelined), a read captured in cycle n drives the bus in cycle n+1 with the `rd_data` value of cycle n, held in an output register.
- R3: A hold command (`cap_cmd` = 2'b00) leaves the drive state and the registered data as they were, so a driven bus stays driven.
- R4: Pipelined with `mode_scd` low (dual-cycle), a deselect (`cap_cmd` = 2'b11) captured in cycle n still lets cycle n drive the data of an earlier read. The bus is undriven from cycle n+1.
- R5: With `mode_scd` high (single-cycle), the bus is undriven in the same cycle the deselect is captured.
- R6: In flow-through mode, a deselect turns the bus off in its own cycle in both deselect modes.
- R7: `oe_n` high forces every lane undriven at once, without waiting for a clock. `oe_n` low only drives lanes the read pipeline has marked active.
- R8: During a write cycle (`cap_cmd` = 2'b10) every lane is undriven. A write also clears the drive state, so a following hold stays undriven.
- R9: All lanes share one drive state: `dq_oe` is either all zeros or all ones.
- R10: `contention_err` is high exactly when a write is captured while `oe_n` is low and the pipeline would have driven the bus in that cycle. This can only occur in pipelined mode, after a read.
- R11: While `rst_n` is low, `dq_oe` and `dq_out` are zero whatever the inputs are. Reset clears the output register and the drive state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_flow_n | input | 1 | Low: flow-through; high: pipelined output register |
| mode_scd | input | 1 | Low: dual-cycle deselect; high: single-cycle deselect |
| oe_n | input | 1 | Asynchronous active-low output enable |
| cap_cmd | input | 2 | Captured command: 00 hold, 01 read, 10 write, 11 deselect |
| rd_data | input | LANES*LANE_W | Array read data for the captured address |
| dq_out | output | LANES*LANE_W | Bus data, zero when a lane is not driven |
| dq_oe | output | LANES | Per-lane drive enable |
| contention_err | output | 1 | Driven read data overlaps a write capture |

## Verification
The two functions that can collide are a pipelined read's delayed drive and a write capture. Both fall in the same cycle when a write immediately follows a read in pipelined mode. The bench provokes this with directed read-then-write pairs, with the output enable both low and high, and through random command streams that switch modes. It judges each cycle by two checks: the bus must be quiet, and the contention flag must match a reference model computed from the requirements.

// File: rtl/rop_pkg.sv
package rop_pkg;

   typedef enum logic [1:0] {
      CMD_HOLD  = 2'b00,
      CMD_READ  = 2'b01,
      CMD_WRITE = 2'b10,
      CMD_DESEL = 2'b11
   } rop_cmd_e;

endpackage

// File: rtl/rop_enable_ctl.sv
module rop_enable_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_flow_n,
   input  logic mode_scd,
   input  logic is_read,
   input  logic is_write,
   input  logic is_desel,
   output logic drv_req
);

   logic en_q;

   // drive state as left by the last non-hold command
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (is_read)
         en_q <= 1'b1;
      else if (is_write || is_desel)
         en_q <= 1'b0;
   end

   // drive request before write masking and output enable
   always_comb begin
      if (!rst_n)
         drv_req = 1'b0;
      else if (!mode_flow_n) begin
         if (is_read)
            drv_req = 1'b1;
         else if (is_write || is_desel)
            drv_req = 1'b0;
         else
            drv_req = en_q;
      end else begin
         if (mode_scd && is_desel)
            drv_req = 1'b0;
         else
            drv_req = en_q;
      end
   end

endmodule

// File: rtl/rop_data_stage.sv
module rop_data_stage #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode_flow_n,
   input  logic                    load,
   input  logic [LANES*LANE_W-1:0] rd_data,
   output logic [LANES*LANE_W-1:0] src_data
);

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] q_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q_r <= '0;
            else if (load)
               q_r <= rd_data[g*LANE_W +: LANE_W];
         end

         assign src_data[g*LANE_W +: LANE_W] =
            mode_flow_n ? q_r : rd_data[g*LANE_W +: LANE_W];
      end
   endgenerate

endmodule

// File: rtl/rop_lane_drv.sv
module rop_lane_drv #(
   parameter int LANE_W = 9
) (
   input  logic              drive,
   input  logic [LANE_W-1:0] src,
   output logic [LANE_W-1:0] dq,
   output logic              oe
);

   assign oe = drive;
   assign dq = drive ? src : '0;

endmodule

// File: rtl/read_out_pipe.sv
module read_out_pipe #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode_flow_n,
   input  logic                    mode_scd,
   input  logic                    oe_n,
   input  logic [1:0]              cap_cmd,
   input  logic [LANES*LANE_W-1:0] rd_data,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic [LANES-1:0]        dq_oe,
   output logic                    contention_err
);
   import rop_pkg::*;

   localparam int BUS_W = LANES * LANE_W;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("read_out_pipe: LANES must be at least 1");
      end
      if (LANE_W < 1) begin : g_bad_width
         $error("read_out_pipe: LANE_W must be at least 1");
      end
   endgenerate

   rop_cmd_e          cmd;
   logic              is_read, is_write, is_desel;
   logic              drv_req, drive;
   logic [BUS_W-1:0]  src_data;

   assign cmd      = rop_cmd_e'(cap_cmd);
   assign is_read  = (cmd == CMD_READ);
   assign is_write = (cmd == CMD_WRITE);
   assign is_desel = (cmd == CMD_DESEL);

   rop_enable_ctl u_en (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_flow_n (mode_flow_n),
      .mode_scd    (mode_scd),
      .is_read     (is_read),
      .is_write    (is_write),
      .is_desel    (is_desel),
      .drv_req     (drv_req)
   );

   rop_data_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_data (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_flow_n (mode_flow_n),
      .load        (is_read),
      .rd_data     (rd_data),
      .src_data    (src_data)
   );

   assign drive          = drv_req & ~is_write & ~oe_n;
   assign contention_err = drv_req &  is_write & ~oe_n;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_drv
         rop_lane_drv #(.LANE_W(LANE_W)) u_lane (
            .drive (drive),
            .src   (src_data[g*LANE_W +: LANE_W]),
            .dq    (dq_out[g*LANE_W +: LANE_W]),
            .oe    (dq_oe[g])
         );
      end
   endgenerate

endmodule

// File: rtl/rop_checker.sv
module rop_checker #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    mode_flow_n,
   input logic                    mode_scd,
   input logic                    oe_n,
   input logic [1:0]              cap_cmd,
   input logic [LANES*LANE_W-1:0] rd_data,
   input logic [LANES*LANE_W-1:0] dq_out,
   input logic [LANES-1:0]        dq_oe,
   input logic                    contention_err
);
   import rop_pkg::*;

   AST_FT_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_flow_n && dq_oe != '0) |-> dq_out == rd_data); // R1

   AST_PL_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_flow_n && cap_cmd == CMD_READ) |=>
      (!mode_flow_n || dq_oe == '0 || dq_out == $past(rd_data))); // R2

   AST_DCD_OFF_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_flow_n && cap_cmd == CMD_DESEL) |=>
      (!mode_flow_n || cap_cmd == CMD_READ || dq_oe == '0)); // R4

   AST_SCD_OFF_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_scd && cap_cmd == CMD_DESEL) |-> dq_oe == '0); // R5

   AST_OE_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> dq_oe == '0); // R7

   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_cmd == CMD_WRITE) |-> dq_oe == '0); // R8

   AST_LANES_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe == '0) || (&dq_oe)); // R9

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      contention_err |-> (cap_cmd == CMD_WRITE && !oe_n && mode_flow_n)); // R10

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (dq_oe == '0 && dq_out == '0)); // R11

endmodule

bind read_out_pipe rop_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_rop_chk (.*);

// File: tb/test_read_out_pipe.sv
module test_read_out_pipe;
   localparam int LANES  = 4;
   localparam int LANE_W = 9;
   localparam int W      = LANES * LANE_W;
   localparam logic [1:0] C_HOLD = 2'b00, C_READ = 2'b01, C_WRITE = 2'b10, C_DESEL = 2'b11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mode_flow_n = 1'b0;
   logic             mode_scd = 1'b1;
   logic             oe_n = 1'b0;
   logic [1:0]       cap_cmd = C_READ;
   logic [W-1:0]     rd_data = W'(36'h5A5A5A5A5);
   logic [W-1:0]     dq_out;
   logic [LANES-1:0] dq_oe;
   logic             contention_err;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   logic en_m = 1'b0;
   logic [W-1:0] data_m = '0;

   always #10 clk = ~clk;

   read_out_pipe #(.LANES(LANES), .LANE_W(LANE_W)) i_read_out_pipe (
      .clk(clk), .rst_n(rst_n), .mode_flow_n(mode_flow_n), .mode_scd(mode_scd),
      .oe_n(oe_n), .cap_cmd(cap_cmd), .rd_data(rd_data), .dq_out(dq_out),
      .dq_oe(dq_oe), .contention_err(contention_err)
   );

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // drive request before write masking and oe, from the requirements
   function automatic logic req_f(input logic fl_n, input logic scd, input logic [1:0] c, input logic en);
      if (!fl_n) return (c == C_READ) ? 1'b1 : (c == C_HOLD) ? en : 1'b0;
      if (scd && c == C_DESEL) return 1'b0;
      return en;
   endfunction

   function automatic string tag_of(input logic [1:0] c, input logic fl_n, input logic scd, input logic o);
      if (o) return "R7";
      case (c)
         C_WRITE: return "R8";
         C_HOLD:  return "R3";
         C_READ:  return fl_n ? "R2" : "R1";
         default: return !fl_n ? "R6" : (scd ? "R5" : "R4");
      endcase
   endfunction

   task automatic step(input logic [1:0] c, input logic [W-1:0] d, input logic o,
                       input int want_on, input string tag);
      logic r, drv, err_e;
      logic [W-1:0] dat_e;
      @(negedge clk);
      cap_cmd = c; rd_data = d; oe_n = o;
      #8;
      r     = req_f(mode_flow_n, mode_scd, c, en_m);
      drv   = r & (c != C_WRITE) & ~o;
      err_e = r & (c == C_WRITE) & ~o;
      dat_e = drv ? (mode_flow_n ? data_m : d) : '0;
      chk(dq_oe == {LANES{drv}}, {tag, " R9 drive"}, W'(dq_oe), W'({LANES{drv}}));
      chk(dq_out == dat_e, {tag, " data"}, dq_out, dat_e);
      chk(contention_err == err_e, "R10 contention", W'(contention_err), W'(err_e));
      if (want_on >= 0)
         chk((dq_oe != '0) == (want_on != 0), {tag, " directed drive"}, W'(dq_oe != '0), W'(want_on));
      @(posedge clk);
      if (c == C_READ) begin en_m = 1'b1; data_m = d; end
      else if (c != C_HOLD) en_m = 1'b0;
   endtask

   function automatic logic [W-1:0] rnd();
      return W'({$urandom(), $urandom()});
   endfunction

   initial begin
      #(20 * 50000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog all requirements actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0005EED1));
      // R11: reset with a flow-through read presented
      repeat (3) @(negedge clk);
      #8;
      chk(dq_oe == '0, "R11 drive in reset", W'(dq_oe), '0);
      chk(dq_out == '0, "R11 data in reset", dq_out, '0);
      @(negedge clk);
      cap_cmd = C_HOLD; rst_n = 1'b1;
      mode_flow_n = 1'b1; mode_scd = 1'b0;
      // R11: output register cleared, hold after reset undriven
      step(C_HOLD, rnd(), 1'b0, 0, "R11");

      // pipelined, dual-cycle deselect
      step(C_READ,  W'(36'h123456789), 1'b0, 0, "R2");
      step(C_HOLD,  W'(36'hFFFFFFFFF), 1'b0, 1, "R2");
      step(C_DESEL, W'(36'h0F0F0F0F0), 1'b0, 1, "R4");
      step(C_HOLD,  W'(36'h0F0F0F0F0), 1'b0, 0, "R4");

      // pipelined, single-cycle deselect
      mode_scd = 1'b1;
      step(C_READ,  W'(36'hABCDEF012), 1'b0, 0, "R2");
      step(C_DESEL, W'(36'h111111111), 1'b0, 0, "R5");

      // flow-through in both deselect modes
      mode_flow_n = 1'b0;
      step(C_READ,  W'(36'h876543210), 1'b0, 1, "R1");
      step(C_HOLD,  W'(36'h222222222), 1'b0, 1, "R3");
      step(C_DESEL, W'(36'h333333333), 1'b0, 0, "R6");
      mode_scd = 1'b0;
      step(C_READ,  W'(36'h444444444), 1'b0, 1, "R1");
      step(C_DESEL, W'(36'h555555555), 1'b0, 0, "R6");

      // write clears drive state
      step(C_READ,  W'(36'h666666666), 1'b0, 1, "R1");
      step(C_WRITE, W'(36'h777777777), 1'b0, 0, "R8");
      step(C_HOLD,  W'(36'h777777777), 1'b0, 0, "R8");

      // read then write in pipelined mode: contention with oe low, none with oe high
      mode_flow_n = 1'b1;
      step(C_READ,  W'(36'h999999999), 1'b0, 0, "R2");
      step(C_WRITE, W'(36'h999999999), 1'b0, 0, "R10");
      step(C_READ,  W'(36'h888888888), 1'b0, 0, "R2");
      step(C_WRITE, W'(36'h888888888), 1'b1, 0, "R10");

      // R7: asynchronous gating inside a driven cycle
      step(C_READ, W'(36'hCAFECAFE1), 1'b0, 0, "R2");
      @(negedge clk);
      cap_cmd = C_HOLD;
      #3;
      chk(dq_oe == '1, "R7 driven before oe", W'(dq_oe), W'({LANES{1'b1}}));
      oe_n = 1'b1; #1;
      chk(dq_oe == '0, "R7 oe high gates off", W'(dq_oe), '0);
      oe_n = 1'b0; #1;
      chk(dq_oe == '1, "R7 oe low re-enables", W'(dq_oe), W'({LANES{1'b1}}));
      @(posedge clk);

      // R7: oe low cannot enable an idle pipeline
      step(C_DESEL, rnd(), 1'b0, -1, "R7");
      step(C_HOLD,  rnd(), 1'b0, 0, "R7");

      // random mix
      for (int i = 0; i < 1500; i++) begin
         logic [1:0] c;
         logic o;
         if (i % 40 == 0) begin
            mode_flow_n = $urandom() % 2;
            mode_scd    = $urandom() % 2;
         end
         c = 2'($urandom() % 4);
         o = ($urandom() % 8 == 0);
         step(c, rnd(), o, -1, tag_of(c, mode_flow_n, mode_scd, o));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule